// File: doc/BRIEF.md
# Microprogram Sequencer with Single Return Register

This block is the sequencing core of a microcoded control unit. A control address register selects one word of an on-chip control store. Each clock edge copies the selected microinstruction into a control buffer register, and the control-signal vector comes straight from that buffer. The same buffered word tells the sequencer where to go next. It can step to the next address, take a branch on a selected status flag, jump to a routine picked from the machine opcode, or come back from a one-level subroutine.

Entry points are formed by placing the opcode in the upper address bits and the status flags just below it. The two lowest bits are left at zero, so every opcode/flag pair gets a slot of four consecutive words. A call saves the address after the calling word into one return register. A later call overwrites it, so nested calls are not supported. The control store holds a small built-in test microprogram that is computed from the address, so the behaviour can be checked at the ports.

Top module: `useq_engine`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, the control address is 0 and the return register is 0. ctrl_o then shows word 0 and fetch_done_o is low.
- R2: A word whose next-select field is 00 (increment), with the call bit clear, makes the next control address equal to the current address plus one, wrapping modulo 2048.
- R3: A word whose next-select field is 01 (branch) jumps to its target when the selected condition is true and otherwise goes to the current address plus one. Condition codes 0, 1 and 2 select flags_i bit 0, 1 and 2. Code 3 is always true.
- R4: A word whose next-select field is 10 (dispatch) makes the next address {opcode_i, flags_i, 2'b00}. The opcode fills address bits 10:5, the flags fill bits 4:2, and bits 1:0 are zero.
- R5: A word with the call bit set jumps to its target whatever its next-select field holds, and stores the current address plus one in the return register.
- R6: A word whose next-select field is 11 (return) loads the control address from the return register. Only the most recent call's return address is held. Words without the call bit leave that register unchanged.
- R7: ctrl_o carries the control field of the word at the current control address. The sequencer advances one microinstruction per clock.
- R8: fetch_done_o is high exactly in the cycles when the buffered word is a dispatch word without the call bit.
- R9: In the built-in test microprogram, every word's control field equals its own address, zero-extended to 16 bits. The sequencing fields are as follows:
  - Words 0 and 1 increment, and word 2 dispatches.
  - Word 8 increments and word 9 returns.
  - Word 12 calls word 8 and word 13 returns.
  - At slot offset 0, opcodes 1, 2 and 3 branch on condition 0, 1 and 2 to that offset-0 address plus 2.
  - At slot offset 0, opcode 4 calls word 8, opcode 5 calls word 12, and opcode 6 returns.
  - Every other word branches always to word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Machine opcode used by dispatch words |
| flags_i | input | 3 | Status flags for branch conditions and dispatch low bits |
| ctrl_o | output | 16 | Control-signal vector from the control buffer register |
| fetch_done_o | output | 1 | High while the dispatch word of the fetch routine is buffered |

## Verification
Dispatch is tried with opcode 0 and flags 0, which lands back on the fetch start, and with opcode 63 and flags 7, which reaches the top of the address space. A middle pattern shows that the opcode bits and the flag bits land in separate fields. Each branch condition is run with its flag set and with that flag clear while other flags are set, which separates a correct flag selection from an OR of all flags. One call followed by its return shows the saved address. A call inside a called routine shows that only the newest return address survives. A return right after a reset shows that the return register was cleared and not kept from a previous run.

// File: rtl/useq_pkg.sv
package useq_pkg;

    parameter int ADDR_W = 11;
    parameter int OPC_W  = 6;
    parameter int FLAG_W = 3;
    parameter int CTRL_W = 16;
    parameter int COND_W = 2;

    localparam int LOW_W  = ADDR_W - OPC_W;
    localparam int SLOT_W = LOW_W - FLAG_W;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        NS_INC      = 2'b00,
        NS_BRANCH   = 2'b01,
        NS_DISPATCH = 2'b10,
        NS_RETURN   = 2'b11
    } nsel_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        nsel_e             nsel;
        logic [COND_W-1:0] cond;
        logic              call;
        addr_t             target;
    } uinstr_t;

    // condition code at or above FLAG_W means "always"
    localparam logic [COND_W-1:0] COND_ALWAYS = COND_W'(FLAG_W);

    // test microprogram landmarks
    localparam addr_t FETCH_START = addr_t'(0);
    localparam addr_t FETCH_STEP  = addr_t'(1);
    localparam addr_t FETCH_LAST  = addr_t'(2);
    localparam addr_t SUB_A       = addr_t'(8);
    localparam addr_t SUB_A_END   = addr_t'(9);
    localparam addr_t SUB_B       = addr_t'(12);
    localparam addr_t SUB_B_END   = addr_t'(13);

    localparam logic [OPC_W-1:0] OPC_BR_FIRST = OPC_W'(1);
    localparam logic [OPC_W-1:0] OPC_BR_LAST  = OPC_W'(FLAG_W);
    localparam logic [OPC_W-1:0] OPC_CALL_A   = OPC_W'(4);
    localparam logic [OPC_W-1:0] OPC_CALL_B   = OPC_W'(5);
    localparam logic [OPC_W-1:0] OPC_RET      = OPC_W'(6);

endpackage

// File: rtl/useq_rom.sv
module useq_rom
    import useq_pkg::*;
(
    input  addr_t   addr_i,
    output uinstr_t word_o
);

    logic [OPC_W-1:0]  opc;
    logic [SLOT_W-1:0] offs;

    assign opc  = addr_i[ADDR_W-1 -: OPC_W];
    assign offs = addr_i[SLOT_W-1:0];

    always_comb begin
        word_o.ctrl   = CTRL_W'(addr_i);
        word_o.nsel   = NS_BRANCH;
        word_o.cond   = COND_ALWAYS;
        word_o.call   = 1'b0;
        word_o.target = FETCH_START;

        if (addr_i == FETCH_START || addr_i == FETCH_STEP || addr_i == SUB_A) begin
            word_o.nsel = NS_INC;
        end else if (addr_i == FETCH_LAST) begin
            word_o.nsel = NS_DISPATCH;
        end else if (addr_i == SUB_A_END || addr_i == SUB_B_END) begin
            word_o.nsel = NS_RETURN;
        end else if (addr_i == SUB_B) begin
            word_o.nsel   = NS_INC;
            word_o.call   = 1'b1;
            word_o.target = SUB_A;
        end else if (offs == '0) begin
            if (opc >= OPC_BR_FIRST && opc <= OPC_BR_LAST) begin
                word_o.cond   = COND_W'(opc - OPC_BR_FIRST);
                word_o.target = addr_i + addr_t'(2);
            end else if (opc == OPC_CALL_A) begin
                word_o.nsel   = NS_INC;
                word_o.call   = 1'b1;
                word_o.target = SUB_A;
            end else if (opc == OPC_CALL_B) begin
                word_o.nsel   = NS_INC;
                word_o.call   = 1'b1;
                word_o.target = SUB_B;
            end else if (opc == OPC_RET) begin
                word_o.nsel = NS_RETURN;
            end
        end
    end

endmodule

// File: rtl/useq_next.sv
module useq_next
    import useq_pkg::*;
(
    input  addr_t             car_i,
    input  addr_t             ret_i,
    input  nsel_e             nsel_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic              call_i,
    input  addr_t             target_i,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [FLAG_W-1:0] flags_i,
    output addr_t             car_o,
    output addr_t             ret_o
);

    logic  cond_true;
    addr_t car_inc;
    addr_t entry;

    assign car_inc = car_i + addr_t'(1);
    assign entry   = {opcode_i, flags_i, {SLOT_W{1'b0}}};

    always_comb begin
        cond_true = 1'b0;
        if (cond_i >= COND_ALWAYS) begin
            cond_true = 1'b1;
        end else begin
            for (int i = 0; i < FLAG_W; i++) begin
                if (cond_i == COND_W'(i)) cond_true = flags_i[i];
            end
        end
    end

    always_comb begin
        ret_o = ret_i;
        car_o = car_inc;
        if (call_i) begin
            car_o = target_i;
            ret_o = car_inc;
        end else begin
            unique case (nsel_i)
                NS_INC:      car_o = car_inc;
                NS_BRANCH:   car_o = cond_true ? target_i : car_inc;
                NS_DISPATCH: car_o = entry;
                NS_RETURN:   car_o = ret_i;
                default:     car_o = car_inc;
            endcase
        end
    end

endmodule

// File: rtl/useq_engine.sv
module useq_engine
    import useq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              fetch_done_o
);

    typedef struct packed {
        addr_t   car;
        addr_t   ret;
        uinstr_t cbr;
    } seq_state_t;

    seq_state_t st_d, st_q;
    addr_t      car_nx, ret_nx;
    uinstr_t    rom_word, rst_word;

    // observation points for the bound checker
    addr_t             car_q, ret_q, target_q;
    nsel_e             nsel_q;
    logic [COND_W-1:0] cond_q;
    logic              call_q;

    assign car_q    = st_q.car;
    assign ret_q    = st_q.ret;
    assign nsel_q   = st_q.cbr.nsel;
    assign cond_q   = st_q.cbr.cond;
    assign call_q   = st_q.cbr.call;
    assign target_q = st_q.cbr.target;

    useq_next u_next (
        .car_i    (st_q.car),
        .ret_i    (st_q.ret),
        .nsel_i   (st_q.cbr.nsel),
        .cond_i   (st_q.cbr.cond),
        .call_i   (st_q.cbr.call),
        .target_i (st_q.cbr.target),
        .opcode_i (opcode_i),
        .flags_i  (flags_i),
        .car_o    (car_nx),
        .ret_o    (ret_nx)
    );

    // store read at the address the CAR is about to take
    useq_rom u_rom (
        .addr_i (car_nx),
        .word_o (rom_word)
    );

    // word loaded into the buffer during reset
    useq_rom u_rom_rst (
        .addr_i (FETCH_START),
        .word_o (rst_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.car = car_nx;
        st_d.ret = ret_nx;
        st_d.cbr = rom_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.car <= FETCH_START;
            st_q.ret <= '0;
            st_q.cbr <= rst_word;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o       = st_q.cbr.ctrl;
    assign fetch_done_o = (st_q.cbr.nsel == NS_DISPATCH) && !st_q.cbr.call;

endmodule

// File: rtl/useq_chk.sv
module useq_chk
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input addr_t             car,
    input addr_t             ret,
    input logic [1:0]        nsel,
    input logic [COND_W-1:0] cond,
    input logic              call,
    input addr_t             target,
    input logic [OPC_W-1:0]  opcode,
    input logic [FLAG_W-1:0] flags,
    input logic              fetch_done
);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (car == '0 && ret == '0)); // R1

    AST_STEP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (nsel == 2'b00 && !call) |=> car == addr_t'($past(car) + addr_t'(1))); // R2

    AST_BRANCH_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (nsel == 2'b01 && !call && cond == COND_ALWAYS) |=> car == $past(target)); // R3

    AST_BRANCH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (nsel == 2'b01 && !call && cond != COND_ALWAYS && flags == '0)
        |=> car == addr_t'($past(car) + addr_t'(1))); // R3

    AST_DISPATCH_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> car == {$past(opcode), $past(flags), {SLOT_W{1'b0}}}); // R4

    AST_CALL_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        call |=> (car == $past(target) && ret == addr_t'($past(car) + addr_t'(1)))); // R5

    AST_RET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !call |=> $stable(ret)); // R6

    AST_RETURN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (nsel == 2'b11 && !call) |=> car == $past(ret)); // R6

endmodule

bind useq_engine useq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .car        (car_q),
    .ret        (ret_q),
    .nsel       (nsel_q),
    .cond       (cond_q),
    .call       (call_q),
    .target     (target_q),
    .opcode     (opcode_i),
    .flags      (flags_i),
    .fetch_done (fetch_done_o)
);

// File: tb/sim_useq_engine.sv
module sim_useq_engine;
    import useq_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic [OPC_W-1:0]  opcode = '0;
    logic [FLAG_W-1:0] flags = '0;
    logic [CTRL_W-1:0] ctrl;
    logic              fetch_done;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    useq_engine u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .opcode_i     (opcode),
        .flags_i      (flags),
        .ctrl_o       (ctrl),
        .fetch_done_o (fetch_done)
    );

    function automatic int entry(int opc, int fl);
        return (opc << LOW_W) | (fl << SLOT_W);
    endfunction

    task automatic check_now(int exp_a, bit exp_fd, string req);
        checks++;
        if (ctrl !== CTRL_W'(exp_a) || fetch_done !== exp_fd) begin
            errors++;
            $display("FAIL %s: ctrl=%0d fetch_done=%0b expected ctrl=%0d fetch_done=%0b",
                     req, ctrl, fetch_done, exp_a, exp_fd);
        end
    endtask

    task automatic step(int exp_a, bit exp_fd, string req);
        @(negedge clk);
        check_now(exp_a, exp_fd, req);
    endtask

    task automatic restart(int opc, int fl);
        @(negedge clk);
        rst_n  = 1'b0;
        opcode = OPC_W'(opc);
        flags  = FLAG_W'(fl);
        @(negedge clk);
        check_now(0, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        check_now(0, 1'b0, "R1 after release");
    endtask

    task automatic fetch();
        step(1, 1'b0, "R2 R7 fetch increment");
        step(2, 1'b1, "R8 fetch done at dispatch word");
    endtask

    task automatic t_reset();
        restart(0, 0);
        step(1, 1'b0, "R1 R2 first step from word 0");
    endtask

    task automatic t_dispatch();
        restart(0, 0);
        fetch();
        step(entry(0, 0), 1'b0, "R4 opcode 0 flags 0");
        step(1, 1'b0, "R2 after low entry");
        restart(63, 7);
        fetch();
        step(entry(63, 7), 1'b0, "R4 opcode 63 flags 7");
        step(0, 1'b0, "R3 R9 always branch to 0");
        restart(10, 5);
        fetch();
        step(entry(10, 5), 1'b0, "R4 opcode 10 flags 5");
        step(0, 1'b0, "R3 R9 always branch to 0");
    endtask

    task automatic br_case(int opc, int fl, bit taken);
        int e;
        e = entry(opc, fl);
        restart(opc, fl);
        fetch();
        step(e, 1'b0, "R4 branch routine entry");
        step(taken ? e + 2 : e + 1, 1'b0, taken ? "R3 branch taken" : "R3 branch fall through");
        step(0, 1'b0, "R3 R9 back to fetch");
    endtask

    task automatic t_branch();
        br_case(1, 1, 1'b1);
        br_case(1, 6, 1'b0);
        br_case(2, 2, 1'b1);
        br_case(2, 5, 1'b0);
        br_case(3, 4, 1'b1);
        br_case(3, 3, 1'b0);
    endtask

    task automatic t_call();
        restart(4, 0);
        fetch();
        step(entry(4, 0), 1'b0, "R4 call routine entry");
        step(8, 1'b0, "R5 call to target");
        step(9, 1'b0, "R2 in subroutine");
        step(entry(4, 0) + 1, 1'b0, "R6 return to caller plus one");
        step(0, 1'b0, "R3 back to fetch");
    endtask

    task automatic t_nested();
        restart(5, 1);
        fetch();
        step(entry(5, 1), 1'b0, "R4 nested routine entry");
        step(12, 1'b0, "R5 outer call");
        step(8, 1'b0, "R5 inner call");
        step(9, 1'b0, "R2 in inner subroutine");
        step(13, 1'b0, "R6 return to latest address");
        step(13, 1'b0, "R6 only latest return kept");
        step(13, 1'b0, "R6 return loops on itself");
    endtask

    task automatic t_ret_clear();
        restart(4, 0);
        fetch();
        step(entry(4, 0), 1'b0, "R4 call routine entry");
        step(8, 1'b0, "R5 call loads return register");
        restart(6, 0);
        fetch();
        step(entry(6, 0), 1'b0, "R4 return routine entry");
        step(0, 1'b0, "R1 R6 return register cleared by reset");
        step(1, 1'b0, "R2 fetch resumes");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1 rst_n = 1'b0;
        t_reset();
        t_dispatch();
        t_branch();
        t_call();
        t_nested();
        t_ret_clear();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule